// File: doc/BRIEF.md
# Receive Byte Buffer with Count Release

This block sits behind a UART deserializer and holds received bytes in a circular RAM until host software collects them. Bytes arrive on a valid/ready stream. The host reads them through a memory-mapped window. Byte zero of the window is always the oldest byte still held. The host does not pop bytes one at a time. After copying a batch, it writes the size of that batch to a release register, and that many of the oldest bytes are freed at once.

Two indications help the host decide when to collect data. The first is a level indication, which goes high when the fill count reaches a programmable threshold. The second is an idle indication. It goes high when some bytes are held but fewer than the threshold, and no byte has arrived and no release has been written for a programmable time. That time is measured in units of four baud-divisor periods.

The receiver cannot stall, so the stream's back-pressure is advisory. `in_ready` drops when the buffer is full. A beat offered while `in_ready` is low is discarded and latches an overrun flag. Register accesses take one cycle. A write takes effect at the clock edge where `reg_wr` is high. Read data appears on `reg_rdata` in the cycle after `reg_rd` was high, and it holds its value until the next read.

Top module: `rxbuf_count_ack`

## Requirements
- R1: After reset the fill count is 0, `in_ready` is 1, and `level_hit`, `char_timeout` and `overrun` are 0. The trigger code reads back as 6, and the idle-time and divisor registers read as 0.
- R2: A beat moves into the buffer when `in_valid` and `in_ready` are both high at a clock edge, and the fill count then rises by one. The usable capacity is 1023 bytes, one less than the 1024-entry RAM. `in_ready` is low exactly when the fill count is 1023.
- R3: A beat offered while `in_ready` is low is dropped and does not change the fill count or the stored data. It sets the sticky `overrun` output. Writing the status word (offset 0x000) with bit 2 set clears `overrun`. If a drop happens in the same cycle as the clear, the drop wins.
- R4: A status read at offset 0x000 returns the fill count split across two fields: bits [31:24] hold fill[7:0] and bits [7:6] hold fill[9:8]. The other status bits are bit 0 = level_hit, bit 1 = char_timeout and bit 2 = overrun; all remaining bits read 0. The data appears on `reg_rdata` one cycle after `reg_rd`.
- R5: A word read at an aligned address A, with 0x004 <= A <= 0x3FC, returns the bytes at positions A-4 to A-1 counted from the oldest byte. The oldest of the four bytes is in bits [7:0]. At most 1020 bytes are therefore visible at once.
- R6: Writing N in bits [15:0] at offset 0x800 frees the N oldest bytes. An N larger than the fill count frees every byte.
- R7: If a beat is accepted in the same cycle as a release write, the fill count becomes fill - min(N, fill) + 1. The release applies to the bytes that were held before that edge.
- R8: The trigger code is a 3-bit field in bits [22:20] at offset 0x804. Code c sets a threshold of 2^(c+2) bytes, from 4 up to 512. `level_hit` is high exactly when the fill count is at least the threshold.
- R9: The idle time register is at offset 0x808, bits [15:0], and the divisor register is at 0x80C, bits [15:0]. The idle limit is L = 4 * idle * divisor cycles. `char_timeout` rises L clock edges after the last accepted beat or release write, provided the fill count stayed between 1 and threshold-1 throughout. A limit of 0 disables the indication.
- R10: `char_timeout` is low whenever the buffer is empty or `level_hit` is high. It drops at the edge of any accepted beat or release write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte is offered |
| in_ready | output | 1 | Buffer has space (fill below 1023) |
| in_data | input | 8 | Received byte |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after reg_rd |
| level_hit | output | 1 | Fill count has reached the trigger threshold |
| char_timeout | output | 1 | Held data has been idle below the threshold for the limit |
| overrun | output | 1 | Sticky flag: a beat was dropped while full |

## Verification
Directed sequences exercise the corner cases:
- an empty buffer, then a known ramp of bytes read back through the window;
- a release smaller than the fill, then one far larger (to expose missing clamping);
- a release landing in the same cycle as a push (to expose wrong ordering of the two updates);
- the whole RAM filled, so that the last readable window word and the dropped beat separate a full condition that is off by one from an overrun that corrupts the data.

For the idle indication, the bench counts edges exactly to the limit. It then restarts the count with a push, and again with a zero-length release. It also checks that the indication stays silent when the buffer is empty and when the level is reached.

A random mix of pushes, releases, combined pushes with releases and trigger-code changes is then compared, after every step, against a queue model. The comparison covers the status word, `in_ready`, `level_hit` and a randomly chosen window word. This catches pointer wrap errors that only show up after the pointers have gone around the RAM.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned AW = 12;

  localparam logic [AW-1:0] OFS_STATUS  = 12'h000;
  localparam logic [AW-1:0] OFS_WIN_LO  = 12'h004;
  localparam logic [AW-1:0] OFS_WIN_END = 12'h400;
  localparam logic [AW-1:0] OFS_RELEASE = 12'h800;
  localparam logic [AW-1:0] OFS_CONFIG  = 12'h804;
  localparam logic [AW-1:0] OFS_IDLE    = 12'h808;
  localparam logic [AW-1:0] OFS_DIV     = 12'h80C;

  localparam int unsigned TRIG_LSB    = 20;
  localparam int unsigned ST_LEVEL    = 0;
  localparam int unsigned ST_TIMEOUT  = 1;
  localparam int unsigned ST_OVERRUN  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_WINDOW,
    SEL_CONFIG,
    SEL_IDLE,
    SEL_DIV
  } rsel_e;

  function automatic logic [31:0] pack_status(input logic [9:0] fill,
                                              input logic lvl,
                                              input logic tmo,
                                              input logic ovr);
    logic [31:0] w;
    w = '0;
    w[31:24] = fill[7:0];
    w[7:6]   = fill[9:8];
    w[ST_LEVEL]   = lvl;
    w[ST_TIMEOUT] = tmo;
    w[ST_OVERRUN] = ovr;
    return w;
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned PTR_W = 10,
  parameter int unsigned REL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             push,
  input  logic             rel_wr,
  input  logic [REL_W-1:0] rel_n,
  input  logic             ovr_clr,
  input  logic [PTR_W-1:0] win_off,
  output logic [31:0]      win_word,
  output logic [PTR_W-1:0] count,
  output logic             overrun
);
  localparam int unsigned DEPTH = 1 << PTR_W;
  localparam logic [PTR_W-1:0] CAP = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W-1:0] rel_amt;
  logic             full;

  assign full     = (count == CAP);
  assign in_ready = ~full;
  assign push     = in_valid & ~full;

  // release size clamped to what is held before this edge
  always_comb begin
    if (!rel_wr)
      rel_amt = '0;
    else if (rel_n > REL_W'(count))
      rel_amt = count;
    else
      rel_amt = rel_n[PTR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      overrun <= 1'b0;
    end else begin
      count   <= count + PTR_W'(push) - rel_amt;
      wr_ptr  <= wr_ptr + PTR_W'(push);
      rd_ptr  <= rd_ptr + rel_amt;
      overrun <= (overrun & ~ovr_clr) | (in_valid & full);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  // four byte lanes of the read window, oldest byte in lane 0
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [PTR_W-1:0] idx;
    assign idx = rd_ptr + win_off + PTR_W'(g);
    assign win_word[8*g +: 8] = mem[idx];
  end

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rel_wr) |=> (count == $past(count) + PTR_W'(1)));

  assert_drop_keeps_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !rel_wr) |=> (count == $past(count) && overrun));

  assert_release_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_wr && rel_n >= REL_W'(count) && !push) |=> (count == '0));
endmodule

// File: rtl/rxb_level.sv
module rxb_level #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  localparam int unsigned TW = CNT_W + 1;

  logic [CODE_W:0] shamt;
  logic [TW-1:0]   thr;

  assign shamt = (CODE_W+1)'(code) + (CODE_W+1)'(2);
  assign thr   = TW'(1) << shamt;
  assign hit   = ({1'b0, count} >= thr);

  assert_hit_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count >= CNT_W'(4)));
endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
  parameter int unsigned IDLE_W = 16,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              restart,
  input  logic [IDLE_W-1:0] idle_val,
  input  logic [DIV_W-1:0]  div_val,
  output logic              expired
);
  localparam int unsigned LIM_W = IDLE_W + DIV_W + 2;

  logic [LIM_W-1:0] limit;
  logic [LIM_W-1:0] cnt;

  assign limit   = (LIM_W'(idle_val) * LIM_W'(div_val)) << 2;
  assign expired = pending && (limit != '0) && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (!pending || restart)
      cnt <= '0;
    else if (cnt < limit)
      cnt <= cnt + LIM_W'(1);
  end

  assert_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);

  assert_reach_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !restart && limit != '0 && cnt == limit - LIM_W'(1))
      |=> (expired || limit != $past(limit)));
endmodule

// File: rtl/rxb_regs.sv
module rxb_regs
  import rxb_pkg::*;
#(
  parameter int unsigned PTR_W    = 10,
  parameter int unsigned REL_W    = 16,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned IDLE_W   = 16,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned RST_CODE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PTR_W-1:0]  count,
  input  logic              lvl,
  input  logic              tmo,
  input  logic              ovr,
  input  logic [31:0]       win_word,
  output logic [PTR_W-1:0]  win_off,
  output logic              rel_wr,
  output logic [REL_W-1:0]  rel_n,
  output logic              ovr_clr,
  output logic [CODE_W-1:0] trig_code,
  output logic [IDLE_W-1:0] idle_val,
  output logic [DIV_W-1:0]  div_val
);
  rsel_e       sel;
  logic        in_win;
  logic [AW-1:0] off_full;

  assign in_win   = (reg_addr >= OFS_WIN_LO) && (reg_addr < OFS_WIN_END) &&
                    (reg_addr[1:0] == 2'b00);
  assign off_full = reg_addr - OFS_WIN_LO;
  assign win_off  = off_full[PTR_W-1:0];

  always_comb begin
    if (reg_addr == OFS_STATUS)      sel = SEL_STATUS;
    else if (in_win)                 sel = SEL_WINDOW;
    else if (reg_addr == OFS_CONFIG) sel = SEL_CONFIG;
    else if (reg_addr == OFS_IDLE)   sel = SEL_IDLE;
    else if (reg_addr == OFS_DIV)    sel = SEL_DIV;
    else                             sel = SEL_NONE;
  end

  assign rel_wr  = reg_wr && (reg_addr == OFS_RELEASE);
  assign rel_n   = reg_wdata[REL_W-1:0];
  assign ovr_clr = reg_wr && (sel == SEL_STATUS) && reg_wdata[ST_OVERRUN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_code <= CODE_W'(RST_CODE);
      idle_val  <= '0;
      div_val   <= '0;
    end else if (reg_wr) begin
      if (sel == SEL_CONFIG) trig_code <= reg_wdata[TRIG_LSB +: CODE_W];
      if (sel == SEL_IDLE)   idle_val  <= reg_wdata[IDLE_W-1:0];
      if (sel == SEL_DIV)    div_val   <= reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd) begin
      case (sel)
        SEL_STATUS: reg_rdata <= pack_status(10'(count), lvl, tmo, ovr);
        SEL_WINDOW: reg_rdata <= win_word;
        SEL_CONFIG: reg_rdata <= 32'(trig_code) << TRIG_LSB;
        SEL_IDLE:   reg_rdata <= 32'(idle_val);
        SEL_DIV:    reg_rdata <= 32'(div_val);
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assert_rdata_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: rtl/rxbuf_count_ack.sv
module rxbuf_count_ack
  import rxb_pkg::*;
#(
  parameter int unsigned PTR_W    = 10,
  parameter int unsigned REL_W    = 16,
  parameter int unsigned CODE_W   = 3,
  parameter int unsigned IDLE_W   = 16,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned RST_CODE = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          level_hit,
  output logic          char_timeout,
  output logic          overrun
);
  logic [PTR_W-1:0]  fill;
  logic [PTR_W-1:0]  win_off;
  logic [31:0]       win_word;
  logic              push, rel_wr, ovr_clr, pending;
  logic [REL_W-1:0]  rel_n;
  logic [CODE_W-1:0] trig_code;
  logic [IDLE_W-1:0] idle_val;
  logic [DIV_W-1:0]  div_val;

  rxb_store #(.PTR_W(PTR_W), .REL_W(REL_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .push(push),
    .rel_wr(rel_wr), .rel_n(rel_n), .ovr_clr(ovr_clr),
    .win_off(win_off), .win_word(win_word),
    .count(fill), .overrun(overrun)
  );

  rxb_level #(.CNT_W(PTR_W), .CODE_W(CODE_W)) u_level (
    .clk(clk), .rst_n(rst_n), .count(fill), .code(trig_code), .hit(level_hit)
  );

  assign pending = (fill != '0) && !level_hit;

  rxb_idle_timer #(.IDLE_W(IDLE_W), .DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .pending(pending), .restart(push | rel_wr),
    .idle_val(idle_val), .div_val(div_val), .expired(char_timeout)
  );

  rxb_regs #(.PTR_W(PTR_W), .REL_W(REL_W), .CODE_W(CODE_W), .IDLE_W(IDLE_W),
             .DIV_W(DIV_W), .RST_CODE(RST_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(fill), .lvl(level_hit), .tmo(char_timeout), .ovr(overrun),
    .win_word(win_word), .win_off(win_off),
    .rel_wr(rel_wr), .rel_n(rel_n), .ovr_clr(ovr_clr),
    .trig_code(trig_code), .idle_val(idle_val), .div_val(div_val)
  );

  assert_timeout_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    char_timeout |-> (fill != '0 && !level_hit));

  assert_drop_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun);
endmodule

// File: tb/rxbuf_count_ack_test.sv
module rxbuf_count_ack_test;
  localparam logic [11:0] A_ST  = 12'h000;
  localparam logic [11:0] A_REL = 12'h800;
  localparam logic [11:0] A_CFG = 12'h804;
  localparam logic [11:0] A_IDL = 12'h808;
  localparam logic [11:0] A_DIV = 12'h80C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        in_ready, level_hit, char_timeout, overrun;
  logic [31:0] reg_rdata;

  int total = 0;
  int bad = 0;
  logic [7:0] mq[$];
  logic movr = 1'b0;
  int   mcode = 6;

  always #10 clk = ~clk;

  rxbuf_count_ack uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .level_hit(level_hit),
    .char_timeout(char_timeout), .overrun(overrun)
  );

  function automatic logic [31:0] exp_status(input logic t);
    logic [9:0] f;
    logic lvl;
    f = 10'(mq.size());
    lvl = (mq.size() >= (1 << (mcode + 2)));
    return {f[7:0], 16'h0, f[9:8], 3'b000, movr, t, lvl};
  endfunction

  function automatic logic [31:0] exp_word(input int off);
    return {mq[off+3], mq[off+2], mq[off+1], mq[off]};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // one cycle of stimulus; the queue model follows the requirements
  task automatic step(input logic pv, input logic [7:0] pb, input logic rw,
                      input logic [11:0] ra, input logic [31:0] wd);
    int n;
    bit acc;
    acc = pv && (mq.size() < 1023);
    in_valid = pv; in_data = pb; reg_wr = rw; reg_addr = ra; reg_wdata = wd;
    cyc();
    in_valid = 1'b0; reg_wr = 1'b0;
    if (rw && ra == A_REL) begin
      n = int'(wd[15:0]);
      if (n > mq.size()) n = mq.size();
      repeat (n) void'(mq.pop_front());
    end
    if (rw && ra == A_CFG) mcode = int'(wd[22:20]);
    if (rw && ra == A_ST && wd[2]) movr = 1'b0;
    if (pv && !acc) movr = 1'b1;
    if (acc) mq.push_back(pb);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    cyc();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    repeat (5) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 flags", {29'd0, level_hit, char_timeout, overrun}, 32'd0);
    rd(A_ST, d);  chk("R1 status", d, 32'd0);
    rd(A_CFG, d); chk("R1 trigger code", d, 32'h0060_0000);
    rd(A_IDL, d); chk("R1 idle reg", d, 32'd0);
    rd(A_DIV, d); chk("R1 div reg", d, 32'd0);

    // R2 R5 ramp in, window read
    for (int i = 0; i < 10; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, A_ST, 0);
    rd(A_ST, d);    chk("R2 R4 fill 10", d, exp_status(1'b0));
    rd(12'h004, d); chk("R5 window word 0", d, 32'hA3A2_A1A0);
    rd(12'h008, d); chk("R5 window word 1", d, 32'hA7A6_A5A4);

    // R6 release and clamp
    step(1'b0, 0, 1'b1, A_REL, 32'd3);
    rd(A_ST, d);    chk("R6 fill after release", d, exp_status(1'b0));
    rd(12'h004, d); chk("R6 window moved", d, 32'hA6A5_A4A3);
    step(1'b0, 0, 1'b1, A_REL, 32'd2000);
    rd(A_ST, d);    chk("R6 clamped release", d, 32'd0);

    // R7 push and release together
    step(1'b1, 8'h11, 1'b0, A_ST, 0);
    step(1'b1, 8'h22, 1'b0, A_ST, 0);
    step(1'b1, 8'h33, 1'b1, A_REL, 32'd1);
    rd(A_ST, d);    chk("R7 fill", d, {8'd2, 24'd0});
    rd(12'h004, d); chk("R7 order", d[15:0], 16'h3322);
    step(1'b0, 0, 1'b1, A_REL, 32'd50);

    // R8 trigger levels
    step(1'b0, 0, 1'b1, A_CFG, 32'h0000_0000);
    for (int i = 0; i < 3; i++) step(1'b1, 8'(i), 1'b0, A_ST, 0);
    chk("R8 below 4", 32'(level_hit), 32'd0);
    step(1'b1, 8'h44, 1'b0, A_ST, 0);
    chk("R8 reach 4", 32'(level_hit), 32'd1);
    step(1'b0, 0, 1'b1, A_CFG, 32'h0010_0000);
    chk("R8 code 1 threshold 8", 32'(level_hit), 32'd0);
    step(1'b0, 0, 1'b1, A_REL, 32'd50);
    step(1'b0, 0, 1'b1, A_CFG, 32'h0060_0000);

    // R9 R10 idle indication, limit 4*3*1 = 12 cycles
    step(1'b0, 0, 1'b1, A_DIV, 32'd1);
    step(1'b0, 0, 1'b1, A_IDL, 32'd3);
    repeat (20) cyc();
    chk("R10 empty stays quiet", 32'(char_timeout), 32'd0);
    step(1'b1, 8'h5A, 1'b0, A_ST, 0);
    repeat (11) cyc();
    chk("R9 one edge before limit", 32'(char_timeout), 32'd0);
    cyc();
    chk("R9 at limit", 32'(char_timeout), 32'd1);
    rd(A_ST, d); chk("R9 R4 status timeout bit", d, exp_status(1'b1));
    step(1'b1, 8'h5B, 1'b0, A_ST, 0);
    chk("R10 push restarts", 32'(char_timeout), 32'd0);
    repeat (12) cyc();
    chk("R9 again at limit", 32'(char_timeout), 32'd1);
    step(1'b0, 0, 1'b1, A_REL, 32'd0);
    chk("R10 release restarts", 32'(char_timeout), 32'd0);
    step(1'b0, 0, 1'b1, A_CFG, 32'h0000_0000);
    step(1'b1, 8'h5C, 1'b0, A_ST, 0);
    step(1'b1, 8'h5D, 1'b0, A_ST, 0);
    repeat (20) cyc();
    chk("R10 quiet at level", 32'(char_timeout), 32'd0);
    step(1'b0, 0, 1'b1, A_IDL, 32'd0);
    step(1'b0, 0, 1'b1, A_REL, 32'd50);
    step(1'b0, 0, 1'b1, A_CFG, 32'h0060_0000);

    // R2 R3 full buffer and overrun
    for (int i = 0; i < 1023; i++) step(1'b1, 8'(i), 1'b0, A_ST, 0);
    chk("R2 ready low when full", 32'(in_ready), 32'd0);
    step(1'b1, 8'hEE, 1'b0, A_ST, 0);
    chk("R3 overrun set", 32'(overrun), 32'd1);
    rd(A_ST, d);    chk("R3 R4 fill held", d, exp_status(1'b0));
    rd(12'h004, d); chk("R3 data intact", d, 32'h0302_0100);
    rd(12'h3FC, d); chk("R5 last window word", d, exp_word(1016));
    step(1'b0, 0, 1'b1, A_ST, 32'h0000_0004);
    chk("R3 overrun cleared", 32'(overrun), 32'd0);
    step(1'b0, 0, 1'b1, A_REL, 32'd1000);
    rd(12'h004, d); chk("R5 R6 window after wrap release", d, exp_word(0));

    // random mix against the model
    for (int it = 0; it < 2500; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 5)
        step(1'b1, 8'($urandom), 1'b0, A_ST, 0);
      else if (op < 7)
        step(1'b0, 0, 1'b1, A_REL, 32'($urandom_range(0, 9)));
      else if (op < 9)
        step(1'b1, 8'($urandom), 1'b1, A_REL, 32'($urandom_range(0, 6)));
      else
        step(1'b0, 0, 1'b1, A_CFG, 32'($urandom_range(0, 7)) << 20);
      chk("R2 random ready", 32'(in_ready), 32'(mq.size() < 1023));
      chk("R8 random level", 32'(level_hit), 32'(mq.size() >= (1 << (mcode + 2))));
      if (it % 4 == 0) begin
        rd(A_ST, d); chk("R4 R7 random status", d, exp_status(1'b0));
      end
      if (mq.size() >= 4 && it % 3 == 0) begin
        int lim, off;
        lim = (mq.size() > 1020) ? 1020 : mq.size();
        off = int'($urandom_range(0, (lim - 4) / 4)) * 4;
        rd(12'(off + 4), d); chk("R5 random window", d, exp_word(off));
      end
    end

    finish_run();
  end
endmodule